// File: doc/BRIEF.md
# Nonvolatile SRAM Mode Controller

This block is the control logic in front of a static RAM that has a nonvolatile shadow array. It turns the active-low chip enable, write enable, output enable and a hardware store strobe into read and write strobes for the array and an enable for the data bus drivers. The store and recall of the shadow array are not modelled here. Their duration is a fixed count of clocks, set by a parameter.

Software can request a nonvolatile cycle without a dedicated pin. It does this with six consecutive chip-enabled read cycles at a fixed list of addresses. Five addresses are shared by both requests, and the sixth address chooses between STORE and RECALL. Pulling the hardware strobe low also requests a STORE. That store is carried out only if the array was written since the last nonvolatile cycle, which the block tracks with a dirty flag. In both cases the block then holds everything off until the strobe is released.

All inputs are sampled on the rising clock edge. One clocked sample with chip enable low counts as one access cycle.

Top module: `nvc_ctrl`

## Requirements
- R1: After reset all outputs are 0. With `ce_n`=1 and `hs_n`=1, `rd_en`, `wr_en` and `dout_en` are 0.
- R2: In the idle state with `hs_n`=1 and `ce_n`=0, `rd_en` follows `we_n`=1 and `wr_en` follows `we_n`=0, in the same cycle.
- R3: `dout_en` is 1 only when `rd_en`=1 and `oe_n`=0, and it is 0 whenever `hs_n`=0. Output enable has no effect on whether a nonvolatile cycle starts.
- R4: A cycle with `wr_en`=1 sets `dirty` at that clock edge.
- R5: If `hs_n` is sampled low in the idle state while `dirty`=1, `store_pulse` is high for one cycle after that edge and `busy` follows. After `busy`, `nv_hold` stays high until `hs_n` is sampled high.
- R6: If `hs_n` is sampled low in the idle state while `dirty`=0, no pulse is issued and `busy` stays low. `nv_hold` rises after that edge and stays high until `hs_n` is sampled high.
- R7: While `busy` or `nv_hold` is 1, `rd_en` and `wr_en` are 0, write cycles leave `dirty` unchanged, and the unlock matcher restarts.
- R8: Six consecutive read cycles at key addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0, in that order, give a one-cycle `store_pulse` after the sixth edge.
- R9: The same first five addresses followed by 0x0C63 give a one-cycle `recall_pulse` after the sixth edge.
- R10: Only `addr[13:0]` is compared with the key list. `addr[14]` is ignored.
- R11: A write cycle during the sequence restarts the matcher. So does a read at an address other than the next expected key. If that mismatched read is at the first key (0x0E38), it counts as step one of a new attempt.
- R12: `busy` lasts exactly `NV_CYCLES` cycles after each pulse. `dirty` is 0 when `busy` falls. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| hs_n | input | 1 | Hardware store strobe, active low |
| addr | input | ADDR_W | Access address |
| rd_en | output | 1 | Array read strobe |
| wr_en | output | 1 | Array write strobe |
| dout_en | output | 1 | Data bus driver enable |
| busy | output | 1 | Nonvolatile cycle in progress |
| nv_hold | output | 1 | Standby hold after a strobe request |
| dirty | output | 1 | Array written since the last nonvolatile cycle |
| store_pulse | output | 1 | One-cycle STORE request |
| recall_pulse | output | 1 | One-cycle RECALL request |

## Verification
The array strobes and the bus enable follow the inputs in the same cycle. `dirty`, the two pulses, `busy` and `nv_hold` change one clock edge after the access or strobe sample that causes them. `busy` then stays high for `NV_CYCLES` edges.

The bench drives each access just after a falling edge and compares every output two time units later. It keeps a reference state that advances on the rising edge, so a registered result is first compared in the cycle after the edge that produced it.

Directed scenes cover these cases:
- a restarted sequence
- the masked upper address bit
- strobes with and without a prior write
- accesses attempted during `busy`

Random cycles are mixed in between them.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

   localparam int KEY_W    = 14;
   localparam int KEY_STEPS = 6;

   typedef enum logic [1:0] {
      NV_IDLE = 2'd0,
      NV_BUSY = 2'd1,
      NV_HOLD = 2'd2
   } nv_state_t;

   // Steps 0..4 are shared; 5 ends a STORE, 6 ends a RECALL.
   function automatic logic [KEY_W-1:0] seq_key(input int unsigned idx);
      case (idx)
         0:       seq_key = 14'h0E38;
         1:       seq_key = 14'h31C7;
         2:       seq_key = 14'h03E0;
         3:       seq_key = 14'h3C1F;
         4:       seq_key = 14'h303F;
         5:       seq_key = 14'h0FC0;
         default: seq_key = 14'h0C63;
      endcase
   endfunction

endpackage

// File: rtl/nvc_mode_decode.sv
module nvc_mode_decode (
   input  logic ce_n,
   input  logic we_n,
   input  logic oe_n,
   input  logic hs_n,
   input  logic nv_idle,
   output logic rd_en,
   output logic wr_en,
   output logic dout_en
);

   logic access_ok;

   always_comb begin
      access_ok = nv_idle & hs_n & ~ce_n;
      rd_en     = access_ok & we_n;
      wr_en     = access_ok & ~we_n;
      dout_en   = access_ok & we_n & ~oe_n;
   end

endmodule

// File: rtl/nvc_seq_match.sv
module nvc_seq_match
   import nvc_pkg::*;
#(
   parameter int KW = KEY_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [KW-1:0] key,
   output logic          fire_store,
   output logic          fire_recall
);

   localparam int LAST     = KEY_STEPS - 1;
   localparam int STEP_W   = $clog2(KEY_STEPS);

   logic [STEP_W-1:0] step_q;
   logic [LAST-1:0]   hit;
   logic              hit_cur;

   generate
      for (genvar gi = 0; gi < LAST; gi++) begin : g_hit
         assign hit[gi] = (key == seq_key(gi));
      end
   endgenerate

   always_comb begin
      hit_cur = 1'b0;
      for (int i = 0; i < LAST; i++) begin
         if (int'(step_q) == i) hit_cur = hit[i];
      end
      fire_store  = rd_en && (int'(step_q) == LAST) && (key == seq_key(LAST));
      fire_recall = rd_en && (int'(step_q) == LAST) && (key == seq_key(LAST + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (clear || wr_en) begin
         step_q <= '0;
      end else if (rd_en) begin
         if (int'(step_q) != LAST && hit_cur) step_q <= step_q + 1'b1;
         else if (hit[0])                     step_q <= STEP_W'(1);
         else                                 step_q <= '0;
      end
   end

endmodule

// File: rtl/nvc_nv_fsm.sv
module nvc_nv_fsm
   import nvc_pkg::*;
#(
   parameter int NV_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_n,
   input  logic wr_en,
   input  logic fire_store,
   input  logic fire_recall,
   output logic nv_idle,
   output logic busy,
   output logic nv_hold,
   output logic dirty,
   output logic store_pulse,
   output logic recall_pulse
);

   localparam int CNT_W = (NV_CYCLES > 1) ? $clog2(NV_CYCLES) : 1;

   nv_state_t        state_q, after_q;
   logic [CNT_W-1:0] cnt_q;

   assign nv_idle = (state_q == NV_IDLE);
   assign busy    = (state_q == NV_BUSY);
   assign nv_hold = (state_q == NV_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= NV_IDLE;
         after_q      <= NV_IDLE;
         cnt_q        <= '0;
         dirty        <= 1'b0;
         store_pulse  <= 1'b0;
         recall_pulse <= 1'b0;
      end else begin
         store_pulse  <= 1'b0;
         recall_pulse <= 1'b0;
         case (state_q)
            NV_IDLE: begin
               if (!hs_n) begin
                  if (dirty) begin
                     state_q     <= NV_BUSY;
                     after_q     <= NV_HOLD;
                     cnt_q       <= CNT_W'(NV_CYCLES - 1);
                     store_pulse <= 1'b1;
                  end else begin
                     state_q <= NV_HOLD;
                  end
               end else if (fire_store || fire_recall) begin
                  state_q      <= NV_BUSY;
                  after_q      <= NV_IDLE;
                  cnt_q        <= CNT_W'(NV_CYCLES - 1);
                  store_pulse  <= fire_store;
                  recall_pulse <= fire_recall;
               end else if (wr_en) begin
                  dirty <= 1'b1;
               end
            end
            NV_BUSY: begin
               if (cnt_q == '0) begin
                  state_q <= after_q;
                  dirty   <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (hs_n) state_q <= NV_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/nvc_ctrl.sv
module nvc_ctrl
   import nvc_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int NV_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              hs_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              rd_en,
   output logic              wr_en,
   output logic              dout_en,
   output logic              busy,
   output logic              nv_hold,
   output logic              dirty,
   output logic              store_pulse,
   output logic              recall_pulse
);

   generate
      if (ADDR_W < KEY_W) begin : g_bad_addr
         $error("nvc_ctrl: ADDR_W must cover the key field");
      end
      if (NV_CYCLES < 1) begin : g_bad_cycles
         $error("nvc_ctrl: NV_CYCLES must be at least 1");
      end
   endgenerate

   logic nv_idle;
   logic fire_store, fire_recall;

   nvc_mode_decode u_dec (
      .ce_n    (ce_n),
      .we_n    (we_n),
      .oe_n    (oe_n),
      .hs_n    (hs_n),
      .nv_idle (nv_idle),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .dout_en (dout_en)
   );

   nvc_seq_match #(.KW(KEY_W)) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (~nv_idle | ~hs_n),
      .rd_en       (rd_en),
      .wr_en       (wr_en),
      .key         (addr[KEY_W-1:0]),
      .fire_store  (fire_store),
      .fire_recall (fire_recall)
   );

   nvc_nv_fsm #(.NV_CYCLES(NV_CYCLES)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .hs_n         (hs_n),
      .wr_en        (wr_en),
      .fire_store   (fire_store),
      .fire_recall  (fire_recall),
      .nv_idle      (nv_idle),
      .busy         (busy),
      .nv_hold      (nv_hold),
      .dirty        (dirty),
      .store_pulse  (store_pulse),
      .recall_pulse (recall_pulse)
   );

endmodule

// File: rtl/nvc_ctrl_chk.sv
module nvc_ctrl_chk #(
   parameter int NV_CYCLES = 8
) (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic oe_n,
   input logic hs_n,
   input logic rd_en,
   input logic wr_en,
   input logic dout_en,
   input logic busy,
   input logic nv_hold,
   input logic dirty,
   input logic store_pulse,
   input logic recall_pulse
);

   logic [31:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= '0;
   end

   // R1
   not_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && hs_n) |-> (!rd_en && !wr_en && !dout_en));

   // R3
   dout_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_n || oe_n) |-> !dout_en);

   // R4
   dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> dirty);

   // R5
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_hold && !hs_n) |=> nv_hold);

   // R7
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || nv_hold) |-> (!rd_en && !wr_en));

   // R8
   pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (store_pulse || recall_pulse) |-> busy);

   // R12
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_pulse && recall_pulse));

   // R12
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == NV_CYCLES && !dirty));

endmodule

bind nvc_ctrl nvc_ctrl_chk #(.NV_CYCLES(NV_CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ce_n         (ce_n),
   .oe_n         (oe_n),
   .hs_n         (hs_n),
   .rd_en        (rd_en),
   .wr_en        (wr_en),
   .dout_en      (dout_en),
   .busy         (busy),
   .nv_hold      (nv_hold),
   .dirty        (dirty),
   .store_pulse  (store_pulse),
   .recall_pulse (recall_pulse)
);

// File: tb/nvc_ctrl_test.sv
module nvc_ctrl_test;

   localparam int PERIOD = 10;
   localparam int AW     = 15;
   localparam int NVC    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, hs_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic rd_en, wr_en, dout_en, busy, nv_hold, dirty, store_pulse, recall_pulse;

   int checks = 0;
   int failures = 0;
   string ctx = "";

   // reference state
   int m_step = 0, m_state = 0, m_after = 0, m_cnt = 0;
   bit m_dirty = 0, m_sp = 0, m_rp = 0;

   always #(PERIOD/2) clk = ~clk;

   nvc_ctrl #(.ADDR_W(AW), .NV_CYCLES(NVC)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .hs_n(hs_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .dout_en(dout_en), .busy(busy), .nv_hold(nv_hold), .dirty(dirty),
      .store_pulse(store_pulse), .recall_pulse(recall_pulse)
   );

   function automatic logic [13:0] key_of(input int i);
      case (i)
         0: return 14'h0E38; 1: return 14'h31C7; 2: return 14'h03E0;
         3: return 14'h3C1F; 4: return 14'h303F; 5: return 14'h0FC0;
         default: return 14'h0C63;
      endcase
   endfunction

   function automatic bit exp_ok();
      return (m_state == 0) && hs_n && !ce_n;
   endfunction

   task automatic chk(input bit act, input bit exp, input string req, input string nm);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s %s: actual=%0b expected=%0b at %0t", req, ctx, nm, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit r;
      r = exp_ok() && we_n;
      chk(rd_en, r, "R2", "rd_en");
      chk(wr_en, exp_ok() && !we_n, "R2", "wr_en");
      chk(dout_en, r && !oe_n, "R3", "dout_en");
      chk(dirty, m_dirty, "R4", "dirty");
      chk(store_pulse, m_sp, "R8", "store_pulse");
      chk(recall_pulse, m_rp, "R9", "recall_pulse");
      chk(busy, m_state == 1, "R12", "busy");
      chk(nv_hold, m_state == 2, "R6", "nv_hold");
   endtask

   always @(posedge clk) begin
      if (rst_n) begin
         bit ok, rd, wr, fs, fr;
         logic [13:0] k;
         ok = exp_ok();
         rd = ok && we_n;
         wr = ok && !we_n;
         k  = addr[13:0];
         fs = rd && m_step == 5 && k == key_of(5);
         fr = rd && m_step == 5 && k == key_of(6);
         m_sp = 0; m_rp = 0;
         case (m_state)
            0: begin
               if (!hs_n) begin
                  m_step = 0;
                  if (m_dirty) begin m_state = 1; m_cnt = NVC-1; m_after = 2; m_sp = 1; end
                  else m_state = 2;
               end else if (fs || fr) begin
                  m_step = 0; m_state = 1; m_cnt = NVC-1; m_after = 0; m_sp = fs; m_rp = fr;
               end else if (wr) begin
                  m_dirty = 1; m_step = 0;
               end else if (rd) begin
                  if (m_step < 5 && k == key_of(m_step)) m_step++;
                  else m_step = (k == key_of(0)) ? 1 : 0;
               end
            end
            1: begin
               m_step = 0;
               if (m_cnt == 0) begin m_state = m_after; m_dirty = 0; end
               else m_cnt--;
            end
            default: begin
               m_step = 0;
               if (hs_n) m_state = 0;
            end
         endcase
      end
   end

   task automatic cyc(input bit c, input bit w, input bit o, input bit h, input logic [AW-1:0] a);
      @(negedge clk);
      ce_n = c; we_n = w; oe_n = o; hs_n = h; addr = a;
      #2;
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, '0);
   endtask

   // sixth key index 5 -> store, 6 -> recall; top bit given
   task automatic unlock(input int last, input bit top);
      for (int i = 0; i < 5; i++) cyc(0, 1, 0, 1, {top, key_of(i)});
      cyc(0, 1, 0, 1, {top, key_of(last)});
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #(PERIOD * 3);
      #1;
      // R1: reset state
      ctx = "R1-reset";
      chk(rd_en | wr_en | dout_en | busy | nv_hold | dirty | store_pulse | recall_pulse,
          1'b0, "R1", "outputs");
      @(negedge clk); rst_n = 1'b1;

      ctx = "R1"; idle(3);

      // R5: write, then strobe with dirty set
      ctx = "R5";
      cyc(0, 0, 1, 1, 15'h0123);
      cyc(0, 1, 0, 1, 15'h0123);
      for (int i = 0; i < NVC + 4; i++) cyc(0, 0, 0, 0, 15'h0456);
      idle(2);

      // R6: strobe without prior write
      ctx = "R6";
      for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, '0);
      idle(2);

      // R10 and R8: store sequence with top bit set, R7 accesses during busy
      ctx = "R10";
      unlock(5, 1'b1);
      ctx = "R7";
      for (int i = 0; i < NVC + 2; i++) cyc(0, (i % 2) == 0, 0, 1, 15'h0777);

      // R9 and R12: recall clears dirty
      ctx = "R9";
      cyc(0, 0, 1, 1, 15'h0001);
      unlock(6, 1'b0);
      idle(NVC + 2);

      // R11: write in the middle aborts
      ctx = "R11-write";
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1, {1'b0, key_of(i)});
      cyc(0, 0, 1, 1, {1'b0, key_of(3)});
      for (int i = 3; i < 6; i++) cyc(0, 1, 0, 1, {1'b0, key_of(i)});
      idle(2);

      // R11: out-of-order first key restarts as step one
      ctx = "R11-restart";
      cyc(0, 1, 0, 1, {1'b0, key_of(0)});
      cyc(0, 1, 0, 1, {1'b0, key_of(1)});
      unlock(5, 1'b0);
      idle(NVC + 2);

      // random mix
      ctx = "rand";
      for (int n = 0; n < 600; n++) begin
         int r;
         r = $urandom % 10;
         if (r < 2) begin
            int bad;
            bad = ($urandom % 4 == 0) ? int'($urandom % 6) : -1;
            for (int i = 0; i < 6; i++) begin
               int ki;
               ki = (i == 5) ? 5 + int'($urandom % 2) : i;
               if (i == bad) cyc(0, $urandom % 2, 0, 1, AW'($urandom));
               else cyc(0, 1, $urandom % 2, 1, {1'($urandom), key_of(ki)});
            end
         end else if (r == 2) begin
            int len;
            len = 1 + int'($urandom % (NVC + 4));
            for (int i = 0; i < len; i++) cyc($urandom % 2, $urandom % 2, $urandom % 2, 0, AW'($urandom));
         end else begin
            cyc(($urandom % 10) < 3, ($urandom % 10) < 7, $urandom % 2, 1, AW'($urandom));
         end
      end
      idle(NVC + 4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule